// File: doc/BRIEF.md
# Multi-standard colour space converter

This block sits at the front of a composite video encoder. It takes 8-bit studio-range luma and colour-difference samples (Y, Cb, Cr) and produces the three signed components that the selected colour standard modulates. The amplitude-modulated standards use a scaled luma plus U and V. The frequency-modulated standard uses a differently scaled luma plus Db and Dr.

Each sample first has its video offsets removed: 16 from luma and 128 from each chroma channel. The result is then multiplied by a fixed-point coefficient chosen per lane and per standard, and rounded to an integer. The amplitude-modulated set is deliberately scaled down so that the final composite signal does not saturate.

A standard-select input travels with each sample through a two-stage pipeline. Samples already in flight keep the standard they entered with. A valid strobe marks the input samples, and the pipeline delays it to mark the outputs.

Top module: `cvbs_csc`

## Requirements
- R1: Offsets are removed before scaling: the luma lane uses (Y−16) and the two chroma lanes use (Cb−128) and (Cr−128). The input Y=16, Cb=128, Cr=128 gives 0 on all three outputs in either standard.
- R2: With `std_sel`=0 (amplitude-modulated set), the coefficients are 2421 for luma, 2064 for U (applied to Cb−128) and 2912 for V (applied to Cr−128). These are round(0.591·4096), round(0.504·4096) and round(0.711·4096). `c1_out` carries U and `c2_out` carries V.
- R3: With `std_sel`=1 (frequency-modulated set), the coefficients are 2560 for luma (0.625), +49 for Db on Cb−128, and −49 for Dr on Cr−128. The value 49 is round(0.0119·4096), and the Dr coefficient is negated. `c1_out` carries Db and `c2_out` carries Dr, so both chroma outputs stay within −2..2.
- R4: Coefficients have 12 fractional bits. Each output equals floor((d·K + 2048) / 4096), where d is the offset-removed input and K is the coefficient. This is round to nearest, with ties going toward +infinity.
- R5: `out_valid` rises exactly two rising clock edges after the edge that captured `in_valid`=1. Back-to-back samples come out back to back.
- R6: The standard is captured together with each sample. A change of `std_sel` affects only samples that enter after the change, including when the standard alternates on every cycle.
- R7: After reset, `out_valid`=0 and all outputs are 0. While `out_valid` is 0, the outputs hold the last valid result, even if the inputs change without a strobe.
- R8: Outputs are 9-bit two's complement. Every input code from 0 to 255 gives an exact, unwrapped result, including the luma extremes (−10..149) and the U/V extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| std_sel | input | 1 | 0 = Y/U/V set, 1 = Y/Db/Dr set |
| y_in | input | 8 | Luma sample |
| cb_in | input | 8 | Blue colour-difference sample |
| cr_in | input | 8 | Red colour-difference sample |
| out_valid | output | 1 | Output strobe |
| y_out | output | 9 | Scaled luma, signed |
| c1_out | output | 9 | U or Db, signed |
| c2_out | output | 9 | V or Dr, signed |

## Verification
The black level with neutral chroma must give exact zeros. This separates correct offset removal from errors that are masked by small coefficients. Code extremes (0, 255 and points near them) are tried in both standards, which exposes a wrong coefficient, a missing Dr sign inversion or a wrapped output. Inputs whose products land exactly on the rounding boundary tell round-half-up apart from truncation. A random stream that alternates the standard every cycle, with gaps in the strobe, separates correct per-sample capture of the standard, correct two-cycle latency and correct output holding from designs that sample the standard late or update on idle cycles.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int PIX_W  = 8;
  localparam int DIFF_W = PIX_W + 1;
  localparam int OUT_W  = 9;
  localparam int COEF_W = 16;
  localparam int LANES  = 3;

  typedef enum logic {STD_AM = 1'b0, STD_FM = 1'b1} std_sel_e;

  // Video offset removed from each lane before scaling.
  function automatic int lane_offset(int lane);
    return (lane == 0) ? 16 : 128;
  endfunction

  // Fixed-point coefficient for a lane, rounded from milli/ten-thousandth units.
  function automatic logic signed [COEF_W-1:0] lane_coef(int lane, std_sel_e std, int frac);
    int one;
    int k;
    one = 1 << frac;
    case (lane)
      0:       k = (std == STD_FM) ? (625 * one + 500) / 1000 : (591 * one + 500) / 1000;
      1:       k = (std == STD_FM) ? (119 * one + 5000) / 10000 : (504 * one + 500) / 1000;
      default: k = (std == STD_FM) ? -((119 * one + 5000) / 10000) : (711 * one + 500) / 1000;
    endcase
    return COEF_W'(k);
  endfunction

  // Multiply, add half an LSB, arithmetic shift: round half toward +inf.
  function automatic logic signed [OUT_W-1:0] scale_round(logic signed [DIFF_W-1:0] d,
                                                           logic signed [COEF_W-1:0] k,
                                                           int frac);
    logic signed [DIFF_W+COEF_W-1:0] p;
    p = d * k;
    p = p + (DIFF_W+COEF_W)'(1 << (frac - 1));
    return OUT_W'(p >>> frac);
  endfunction
endpackage

// File: rtl/csc_offset_stage.sv
module csc_offset_stage
  import csc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  std_sel_e                      std_in,
  input  logic [LANES-1:0][PIX_W-1:0]   pix,
  output logic                          s1_valid,
  output std_sel_e                      s1_std,
  output logic [LANES-1:0][DIFF_W-1:0]  s1_diff
);
  logic [LANES-1:0][DIFF_W-1:0] diff_d;

  for (genvar i = 0; i < LANES; i++) begin : g_off
    assign diff_d[i] = {1'b0, pix[i]} - DIFF_W'(lane_offset(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        s1_diff[i] <= '0;
      else if (in_valid) s1_diff[i] <= diff_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_std   <= STD_AM;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_std <= std_in;
    end
  end

  // R5: first stage follows the strobe by one edge
  assert_stage1_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid == $past(in_valid));
  // R6: the standard is latched with the sample it accompanies
  assert_std_captured_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_std == $past(std_in));
  // R1: luma lane offset of 16
  assert_luma_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $signed(s1_diff[0]) == $signed({1'b0, $past(pix[0])}) - 16);
endmodule

// File: rtl/csc_scale_lane.sv
module csc_scale_lane
  import csc_pkg::*;
#(
  parameter int LANE = 0,
  parameter int FRAC = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  std_sel_e                 std_in,
  input  logic [DIFF_W-1:0]        diff,
  output logic signed [OUT_W-1:0]  q
);
  logic signed [COEF_W-1:0] coef;
  logic signed [OUT_W-1:0]  q_d;

  assign coef = lane_coef(LANE, std_in, FRAC);
  assign q_d  = scale_round($signed(diff), coef, FRAC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= q_d;
  end

  // R7: the lane keeps its result on idle cycles
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

  if (LANE != 0) begin : g_fm_chroma
    // R3: FM chroma components are tiny after scaling
    assert_fm_chroma_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && std_in == STD_FM) |=> (q >= -2 && q <= 2));
  end else begin : g_luma
    // R8: luma never wraps
    assert_luma_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q >= -10 && q <= 149));
  end
endmodule

// File: rtl/cvbs_csc.sv
module cvbs_csc
  import csc_pkg::*;
#(
  parameter int FRAC = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     std_sel,
  input  logic [PIX_W-1:0]         y_in,
  input  logic [PIX_W-1:0]         cb_in,
  input  logic [PIX_W-1:0]         cr_in,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  y_out,
  output logic signed [OUT_W-1:0]  c1_out,
  output logic signed [OUT_W-1:0]  c2_out
);
  logic                          s1_valid;
  std_sel_e                      s1_std;
  logic [LANES-1:0][DIFF_W-1:0]  s1_diff;
  logic [LANES-1:0][PIX_W-1:0]   pix;
  logic signed [OUT_W-1:0]       lane_q [LANES];

  assign pix = {cr_in, cb_in, y_in};

  csc_offset_stage u_off (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .std_in   (std_sel_e'(std_sel)),
    .pix      (pix),
    .s1_valid (s1_valid),
    .s1_std   (s1_std),
    .s1_diff  (s1_diff)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    csc_scale_lane #(.LANE(i), .FRAC(FRAC)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (s1_valid),
      .std_in (s1_std),
      .diff   (s1_diff[i]),
      .q      (lane_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_valid;
  end

  assign y_out  = lane_q[0];
  assign c1_out = lane_q[1];
  assign c2_out = lane_q[2];

  // R5: output strobe follows the first stage by one edge
  assert_out_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s1_valid));
  // R1: black level with neutral chroma yields zeros
  assert_zero_point_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_diff == '0) |=> (y_out == 0 && c1_out == 0 && c2_out == 0));
  // R7: whole output word stays put while the strobe is low
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(y_out) && $stable(c1_out) && $stable(c2_out)));
endmodule

// File: tb/tb_cvbs_csc.sv
module tb_cvbs_csc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       std_sel = 1'b0;
  logic [7:0] y_in = 8'd0, cb_in = 8'd0, cr_in = 8'd0;
  logic       out_valid;
  logic signed [8:0] y_out, c1_out, c2_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit mon_en = 0;
  string cur_tag = "R2";

  always #5 clk = ~clk;

  cvbs_csc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .std_sel(std_sel),
    .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
    .out_valid(out_valid), .y_out(y_out), .c1_out(c1_out), .c2_out(c2_out)
  );

  // Coefficients restated from the requirements (12 fractional bits).
  int kY_am, kU, kV, kY_fm, kDb, kDr;
  initial begin
    kY_am = $rtoi(0.591 * 4096.0 + 0.5);
    kU    = $rtoi(0.504 * 4096.0 + 0.5);
    kV    = $rtoi(0.711 * 4096.0 + 0.5);
    kY_fm = $rtoi(0.625 * 4096.0 + 0.5);
    kDb   = $rtoi(0.0119 * 4096.0 + 0.5);
    kDr   = -kDb;
  end

  function automatic int rnd(int d, int k);
    return $rtoi($floor(real'(d) * real'(k) / 4096.0 + 0.5));
  endfunction

  // Expected-value pipeline, two stages deep.
  bit    e1_v, e2_v;
  int    e1_y, e1_a, e1_b, e2_y, e2_a, e2_b;
  string e1_t, e2_t;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1_v <= 0; e2_v <= 0;
      e1_y <= 0; e1_a <= 0; e1_b <= 0;
      e2_y <= 0; e2_a <= 0; e2_b <= 0;
      e1_t <= "R7"; e2_t <= "R7";
    end else begin
      e2_v <= e1_v;
      if (e1_v) begin
        e2_y <= e1_y; e2_a <= e1_a; e2_b <= e1_b; e2_t <= e1_t;
      end
      e1_v <= in_valid;
      if (in_valid) begin
        e1_t <= cur_tag;
        if (std_sel) begin
          e1_y <= rnd(int'(y_in) - 16, kY_fm);
          e1_a <= rnd(int'(cb_in) - 128, kDb);
          e1_b <= rnd(int'(cr_in) - 128, kDr);
        end else begin
          e1_y <= rnd(int'(y_in) - 16, kY_am);
          e1_a <= rnd(int'(cb_in) - 128, kU);
          e1_b <= rnd(int'(cr_in) - 128, kV);
        end
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Compare every cycle away from the active edge.
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      check("R5", "out_valid", int'(out_valid), int'(e2_v));
      check(e2_v ? e2_t : "R7", "y_out",  int'(y_out),  e2_y);
      check(e2_v ? e2_t : "R7", "c1_out", int'(c1_out), e2_a);
      check(e2_v ? e2_t : "R7", "c2_out", int'(c2_out), e2_b);
    end
  end

  task automatic drive(bit v, bit s, int y, int cb, int cr);
    @(negedge clk);
    in_valid = v; std_sel = s;
    y_in = 8'(y); cb_in = 8'(cb); cr_in = 8'(cr);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, std_sel, y_in, cb_in, cr_in);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R7", "reset out_valid", int'(out_valid), 0);
    check("R7", "reset y_out", int'(y_out), 0);
    check("R7", "reset c1_out", int'(c1_out), 0);
    check("R7", "reset c2_out", int'(c2_out), 0);
  endtask

  task automatic t_zero_point;
    cur_tag = "R1";
    drive(1, 0, 16, 128, 128);
    drive(1, 1, 16, 128, 128);
    idle(3);
    check("R1", "checks ran", int'(checks > 0), 1);
  endtask

  task automatic t_am_extremes;
    cur_tag = "R2";
    drive(1, 0, 255, 255, 255);
    drive(1, 0, 0, 0, 0);
    cur_tag = "R8";
    drive(1, 0, 235, 240, 16);
    drive(1, 0, 1, 127, 129);
    idle(3);
  endtask

  task automatic t_fm_extremes;
    cur_tag = "R3";
    drive(1, 1, 255, 255, 255);
    drive(1, 1, 0, 0, 0);
    drive(1, 1, 100, 200, 50);
    cur_tag = "R8";
    drive(1, 1, 239, 1, 254);
    idle(3);
  endtask

  task automatic t_rounding;
    cur_tag = "R4";
    // Cb-128 = -2 with U: -4128/4096 -> -1; y sweeps land on many fractions
    for (int i = 0; i < 32; i++) drive(1, i % 2, 16 + i, 126 + i, 130 - i);
    idle(3);
  endtask

  task automatic t_mode_alternate;
    cur_tag = "R6";
    for (int i = 0; i < 40; i++) drive(1, i % 2, 200, 30, 220);
    idle(3);
  endtask

  task automatic t_gaps_hold;
    cur_tag = "R7";
    for (int i = 0; i < 300; i++) begin
      bit v;
      v = ($urandom % 3) != 0;
      drive(v, $urandom % 2, $urandom % 256, $urandom % 256, $urandom % 256);
    end
    idle(3);
  endtask

  task automatic t_backtoback;
    cur_tag = "R5";
    for (int i = 0; i < 256; i++) drive(1, i[5], i, 255 - i, i);
    idle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    mon_en = 1;
    t_zero_point();
    t_am_extremes();
    t_fm_extremes();
    t_rounding();
    t_mode_alternate();
    t_backtoback();
    t_gaps_hold();
    mon_en = 0;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule